// File: doc/BRIEF.md
# Dual-LUT Configurable Logic Tile

This block is one logic tile of a programmable fabric. It holds two 4-input lookup tables, called F and G, each defined by a 16-entry truth table. A third, 3-input generator called H combines the F result, the G result and one extra input. A single tile can therefore implement some functions of up to nine variables. Two storage elements can capture a generator result or a direct data bit. Each can run as an edge-triggered flip-flop or as a level-sensitive latch. A dedicated carry path forms an arithmetic carry for the next tile in a chain.

The tile's behaviour is set by a configuration word. The word enters one bit per clock through a serial port and takes effect only when a load strobe is pulsed. Four control pins are shared between the two storage elements. Configuration gives each pin one of four roles: data, clock enable, set or reset. Each of the two outputs can be switched between a combinational generator result and a storage element output.

Top module: `clb_tile`

## Requirements
- R1: Configuration bits enter MSB first, one per `clk` edge while `cfg_shift_en` is high. The 58-bit word, from MSB to LSB, is:
  - F table (16)
  - G table (16)
  - H table (8)
  - control roles (8, two bits per pin, pin 3 first)
  - X storage source (2)
  - Y storage source (2)
  - X combinational H-select
  - Y combinational H-select
  - X registered-output select
  - Y registered-output select
  - latch mode
  - carry enable

  The shifted word replaces the active configuration only on the clock edge at which `cfg_load` is high. Until then the tile keeps its previous behaviour.
- R2: While `rst_n` is low at a clock edge, the active configuration is cleared to all zeros. After reset the outputs read 0 and `carry_out` equals `carry_in`.
- R3: The F output equals bit `{f_in[3],f_in[2],f_in[1],f_in[0]}` of the F table. The G output equals bit `g_in` of the G table.
- R4: The H output equals bit `{h_in, G output, F output}` of the 8-bit H table.
- R5: The combinational result for X is F when its H-select bit is 0 and H when it is 1; Y uses G or H in the same way. Each output presents its combinational result when its registered-output bit is 0 and its storage element when that bit is 1.
- R6: The storage source codes are 0 = F, 1 = G, 2 = H and 3 = direct data. In flip-flop mode the element captures the selected value on the rising clock edge when it is enabled.
- R7: Role codes are 0 = data, 1 = clock enable, 2 = set and 3 = reset. Several pins may share a role, and their values are ORed. The enable is 1 when no pin has the enable role.
- R8: Set and reset act at once, without a clock edge. Set has priority over reset. An element that was set or reset keeps that value after the pin is released.
- R9: In latch mode, an enabled element is transparent while `clk` is high. It holds the value present at the falling edge while `clk` is low.
- R10: When carry is enabled:
  - F's table index bit 3 is taken from `carry_in` instead of `f_in[3]`.
  - `carry_out` is the majority of `f_in[0]`, `g_in[0]` and `carry_in`.

  When carry is disabled, `carry_out` equals `carry_in`.
- R11: Any clock edge with `cfg_shift_en` or `cfg_load` high clears both storage elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock, also used for configuration shifting |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift_en | input | 1 | Shift one configuration bit in on this edge |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| cfg_load | input | 1 | Copy the shifted word into the active configuration |
| f_in | input | 4 | F lookup table inputs |
| g_in | input | 4 | G lookup table inputs |
| h_in | input | 1 | Extra input of the H generator |
| ctl | input | 4 | Shared control pins with configurable roles |
| carry_in | input | 1 | Carry from the neighbouring tile |
| carry_out | output | 1 | Carry to the neighbouring tile |
| x_out | output | 1 | First tile output |
| y_out | output | 1 | Second tile output |

## Verification
The bench sweeps every index of F, G and H exhaustively and the full carry truth table. A wrong bit order in the H index or the F index would show up as a swapped table entry. The bench asserts set and reset together and samples between clock edges. A design that gives reset priority, or that applies set and reset only at an edge, would show a stale or wrong value there. Latch mode is probed both inside the high phase and after the falling edge, which exposes a latch that behaves like a flop. Shifting without a load must leave the old behaviour intact, and a hold during shifting must clear the storage; a design that loads early or keeps stale state fails those checks.

// File: rtl/clb_pkg.sv
// Package: shared sizes, role and source codes, and the layout of the
// configuration word of the logic tile. Field order is MSB first.
package clb_pkg;
    localparam int LUT_K  = 4;
    localparam int LUT_SZ = 1 << LUT_K;
    localparam int H_K    = 3;
    localparam int H_SZ   = 1 << H_K;
    localparam int N_CTL  = 4;
    localparam int N_ST   = 2;

    typedef enum logic [1:0] {
        ROLE_DATA = 2'd0,
        ROLE_EN   = 2'd1,
        ROLE_SET  = 2'd2,
        ROLE_RST  = 2'd3
    } ctl_role_e;

    typedef enum logic [1:0] {
        SRC_F   = 2'd0,
        SRC_G   = 2'd1,
        SRC_H   = 2'd2,
        SRC_DIN = 2'd3
    } st_src_e;

    typedef struct packed {
        logic [LUT_SZ-1:0]     f_tt;
        logic [LUT_SZ-1:0]     g_tt;
        logic [H_SZ-1:0]       h_tt;
        logic [N_CTL-1:0][1:0] role;
        logic [1:0]            x_src;
        logic [1:0]            y_src;
        logic                  x_hsel;
        logic                  y_hsel;
        logic                  x_reg;
        logic                  y_reg;
        logic                  latch_mode;
        logic                  carry_en;
    } clb_cfg_t;

    localparam int CFG_W = $bits(clb_cfg_t);
endpackage

// File: rtl/clb_cfg_chain.sv
// Module: serial configuration chain.
// Shifts bits in MSB first while shift_en is high and copies the whole
// shift register into the active word on a load strobe.
// Assumes a single clock shared with the tile; rst_n is synchronous.
module clb_cfg_chain #(
    parameter int W = 58
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    input  logic         load,
    output logic [W-1:0] cfg_q,
    output logic         loading
);
    logic [W-1:0] shreg;

    // Purpose: serial shift register, newest bit in the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (shift_en)
            shreg <= {shreg[W-2:0], din};
    end

    // Purpose: active configuration, updated only by the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (load)
            cfg_q <= shreg;
    end

    // Purpose: flag telling the storage elements to stay cleared.
    assign loading = shift_en | load;
endmodule

// File: rtl/clb_lut.sv
// Module: generic K-input lookup table.
// The output is the truth-table bit addressed by the index.
// Assumes the table is static between configuration loads.
module clb_lut #(
    parameter int K = 4,
    localparam int SZ = 1 << K
) (
    input  logic [SZ-1:0] tt,
    input  logic [K-1:0]  idx,
    output logic          o
);
    // Purpose: table read.
    assign o = tt[idx];
endmodule

// File: rtl/clb_carry.sv
// Module: dedicated carry path between neighbouring tiles.
// In carry mode it forms the majority of two operand bits and the
// incoming carry; otherwise it passes the incoming carry through.
module clb_carry (
    input  logic en,
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic cout
);
    logic gen_c;
    logic prop_c;

    // Purpose: generate and propagate terms, then the selected carry.
    always_comb begin
        gen_c  = a & b;
        prop_c = a ^ b;
        cout   = en ? (gen_c | (prop_c & cin)) : cin;
    end
endmodule

// File: rtl/clb_ctl_map.sv
// Module: maps the shared control pins onto the four internal roles.
// Pins sharing a role are ORed. The enable reads 1 when no pin is
// mapped to the enable role.
module clb_ctl_map #(
    parameter int N = 4
) (
    input  logic [N-1:0][1:0] role,
    input  logic [N-1:0]      pins,
    output logic              dat,
    output logic              en,
    output logic              aset,
    output logic              arst
);
    logic en_any;
    logic en_or;

    // Purpose: decode each pin's role and fold the pins per role.
    always_comb begin
        dat    = 1'b0;
        en_any = 1'b0;
        en_or  = 1'b0;
        aset   = 1'b0;
        arst   = 1'b0;
        for (int i = 0; i < N; i++) begin
            case (role[i])
                2'd0: dat = dat | pins[i];
                2'd1: begin
                    en_any = 1'b1;
                    en_or  = en_or | pins[i];
                end
                2'd2: aset = aset | pins[i];
                default: arst = arst | pins[i];
            endcase
        end
        en = en_any ? en_or : 1'b1;
    end
endmodule

// File: rtl/clb_storage.sv
// Module: one tile storage element, acting as a flip-flop or a latch.
// Flip-flop mode captures on the rising edge. Latch mode is transparent
// while clk is high and holds the value sampled at the falling edge.
// Set beats reset, and both override the stored value at once.
// hold and rst_n clear the element synchronously.
module clb_storage (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic latch_mode,
    input  logic d,
    input  logic en,
    input  logic aset,
    input  logic arst,
    output logic q
);
    logic q_rise;
    logic q_fall;

    // Purpose: edge-triggered state for flip-flop mode.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            q_rise <= 1'b0;
        else if (aset)
            q_rise <= 1'b1;
        else if (arst)
            q_rise <= 1'b0;
        else if (en)
            q_rise <= d;
    end

    // Purpose: value held by the latch once clk goes low.
    always_ff @(negedge clk) begin
        if (!rst_n || hold)
            q_fall <= 1'b0;
        else if (aset)
            q_fall <= 1'b1;
        else if (arst)
            q_fall <= 1'b0;
        else if (en)
            q_fall <= d;
    end

    // Purpose: output with immediate set/reset override and latch transparency.
    always_comb begin
        if (aset)
            q = 1'b1;
        else if (arst)
            q = 1'b0;
        else if (latch_mode)
            q = (clk && en && !hold && rst_n) ? d : q_fall;
        else
            q = q_rise;
    end
endmodule

// File: rtl/clb_tile.sv
// Module: dual-LUT configurable logic tile (top).
// Contains F and G 4-input tables, an H generator over {h_in,G,F}, two
// storage elements, control-pin role mapping and a carry path.
// Assumes configuration changes only through the serial chain.
module clb_tile
    import clb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift_en,
    input  logic             cfg_din,
    input  logic             cfg_load,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h_in,
    input  logic [N_CTL-1:0] ctl,
    input  logic             carry_in,
    output logic             carry_out,
    output logic             x_out,
    output logic             y_out
);
    logic [CFG_W-1:0] cfg_bits;
    clb_cfg_t         cfg_act;
    logic             loading;
    logic [LUT_K-1:0] f_idx;
    logic             f_o;
    logic             g_o;
    logic             h_o;
    logic             x_comb;
    logic             y_comb;
    logic             dat_act;
    logic             en_act;
    logic             set_act;
    logic             rst_act;
    logic [N_ST-1:0]  st_q;

    clb_cfg_chain #(.W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .din      (cfg_din),
        .load     (cfg_load),
        .cfg_q    (cfg_bits),
        .loading  (loading)
    );

    // Purpose: view the active bits through the field layout.
    assign cfg_act = clb_cfg_t'(cfg_bits);

    // Purpose: F top index bit comes from the carry in carry mode.
    always_comb begin
        f_idx = f_in;
        if (cfg_act.carry_en)
            f_idx[LUT_K-1] = carry_in;
    end

    clb_lut #(.K(LUT_K)) u_f (
        .tt  (cfg_act.f_tt),
        .idx (f_idx),
        .o   (f_o)
    );

    clb_lut #(.K(LUT_K)) u_g (
        .tt  (cfg_act.g_tt),
        .idx (g_in),
        .o   (g_o)
    );

    clb_lut #(.K(H_K)) u_h (
        .tt  (cfg_act.h_tt),
        .idx ({h_in, g_o, f_o}),
        .o   (h_o)
    );

    clb_carry u_carry (
        .en   (cfg_act.carry_en),
        .a    (f_in[0]),
        .b    (g_in[0]),
        .cin  (carry_in),
        .cout (carry_out)
    );

    clb_ctl_map #(.N(N_CTL)) u_ctl (
        .role (cfg_act.role),
        .pins (ctl),
        .dat  (dat_act),
        .en   (en_act),
        .aset (set_act),
        .arst (rst_act)
    );

    // Purpose: combinational results for the two outputs.
    assign x_comb = cfg_act.x_hsel ? h_o : f_o;
    assign y_comb = cfg_act.y_hsel ? h_o : g_o;

    // Purpose: one storage element per output, each with its own source.
    for (genvar i = 0; i < N_ST; i++) begin : g_st
        logic [1:0] src;
        logic       d_sel;

        assign src = (i == 0) ? cfg_act.x_src : cfg_act.y_src;

        // Purpose: select the storage data source.
        always_comb begin
            case (src)
                2'd0:    d_sel = f_o;
                2'd1:    d_sel = g_o;
                2'd2:    d_sel = h_o;
                default: d_sel = dat_act;
            endcase
        end

        clb_storage u_st (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold       (loading),
            .latch_mode (cfg_act.latch_mode),
            .d          (d_sel),
            .en         (en_act),
            .aset       (set_act),
            .arst       (rst_act),
            .q          (st_q[i])
        );
    end

    // Purpose: output select between combinational and stored values.
    assign x_out = cfg_act.x_reg ? st_q[0] : x_comb;
    assign y_out = cfg_act.y_reg ? st_q[1] : y_comb;
endmodule

// File: rtl/clb_tile_chk.sv
// Module: property checker for the logic tile, bound into clb_tile.
module clb_tile_chk
    import clb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_load,
    input logic            loading,
    input clb_cfg_t        cfg_act,
    input logic            carry_in,
    input logic            carry_out,
    input logic            set_act,
    input logic            rst_act,
    input logic [N_ST-1:0] st_q
);
    AST_CFG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cfg_act == '0)); // R2
    AST_CFG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_load) |-> $stable(cfg_act)); // R1
    AST_CARRY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_act.carry_en |-> (carry_out == carry_in)); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_act |-> (st_q == '1)); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_act && !set_act) |-> (st_q == '0)); // R8
    AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(loading) && !set_act && !cfg_act.latch_mode) |-> (st_q == '0)); // R11
endmodule

bind clb_tile clb_tile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .loading   (loading),
    .cfg_act   (cfg_act),
    .carry_in  (carry_in),
    .carry_out (carry_out),
    .set_act   (set_act),
    .rst_act   (rst_act),
    .st_q      (st_q)
);

// File: tb/tb_clb_tile.sv
`timescale 1ns/10ps
module tb_clb_tile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_shift_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_load = 1'b0;
    logic [3:0] f_in = '0;
    logic [3:0] g_in = '0;
    logic       h_in = 1'b0;
    logic [3:0] ctl = '0;
    logic       carry_in = 1'b0;
    logic       carry_out;
    logic       x_out;
    logic       y_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    clb_tile dut (
        .clk (clk), .rst_n (rst_n), .cfg_shift_en (cfg_shift_en),
        .cfg_din (cfg_din), .cfg_load (cfg_load), .f_in (f_in),
        .g_in (g_in), .h_in (h_in), .ctl (ctl), .carry_in (carry_in),
        .carry_out (carry_out), .x_out (x_out), .y_out (y_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Waits for the rising edge, then 1 ns.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [57:0] mk_cfg(
        input logic [15:0] f, input logic [15:0] g, input logic [7:0] h,
        input logic [7:0] roles, input logic [1:0] xs, input logic [1:0] ys,
        input logic xh, input logic yh, input logic xr, input logic yr,
        input logic lm, input logic ce);
        return {f, g, h, roles, xs, ys, xh, yh, xr, yr, lm, ce};
    endfunction

    task automatic load_cfg(input logic [57:0] w, input bit do_load);
        for (int i = 57; i >= 0; i--) begin
            cfg_shift_en = 1'b1;
            cfg_din = w[i];
            step();
        end
        cfg_shift_en = 1'b0;
        if (do_load) begin
            cfg_load = 1'b1;
            step();
            cfg_load = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] ftt;
        logic [15:0] gtt;
        logic [7:0]  htt;
        logic        fo;
        logic        go;
        repeat (4) step();
        rst_n = 1'b1;
        carry_in = 1'b1;
        #2;
        // R2: cleared configuration after reset
        chk("R2 x", x_out, 1'b0);
        chk("R2 y", y_out, 1'b0);
        chk("R2 carry", carry_out, 1'b1);
        carry_in = 1'b0;

        // R1: shifted word acts only after load
        step();
        load_cfg(mk_cfg(16'h8000, 16'h0, 8'h0, 8'h0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0), 1);
        f_in = 4'hF;
        #2 chk("R1 loaded", x_out, 1'b1);
        step();
        load_cfg(mk_cfg(16'h0000, 16'h0, 8'h0, 8'h0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0), 0);
        #2 chk("R1 not yet loaded", x_out, 1'b1);
        step();
        cfg_load = 1'b1;
        step();
        cfg_load = 1'b0;
        #2 chk("R1 after load", x_out, 1'b0);
        step();

        // R3: exhaustive F and G sweep, combinational outputs
        ftt = 16'hA5C3;
        gtt = 16'h36E1;
        load_cfg(mk_cfg(ftt, gtt, 8'h0, 8'h0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0), 1);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                f_in = 4'(a);
                g_in = 4'(b);
                #0.5;
                chk("R3 F", x_out, ftt[a]);
                chk("R3 G", y_out, gtt[b]);
            end
        end
        step();

        // R4/R5: H over {h_in, G, F}, both outputs through H
        htt = 8'b1001_0110;
        ftt = 16'h6996;
        gtt = 16'hF0F0;
        load_cfg(mk_cfg(ftt, gtt, htt, 8'h0, 2'd0, 2'd0, 1, 1, 0, 0, 0, 0), 1);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 2; c++) begin
                    f_in = 4'(a);
                    g_in = 4'(b);
                    h_in = 1'(c);
                    fo = ftt[a];
                    go = gtt[b];
                    #0.5;
                    chk("R4 H", x_out, htt[{h_in, go, fo}]);
                    chk("R5 hsel y", y_out, htt[{h_in, go, fo}]);
                end
            end
        end
        step();

        // R6/R5: registered outputs, X from F and Y from H
        load_cfg(mk_cfg(ftt, gtt, htt, 8'h0, 2'd0, 2'd2, 0, 0, 1, 1, 0, 0), 1);
        for (int a = 0; a < 16; a++) begin
            for (int c = 0; c < 2; c++) begin
                f_in = 4'(a);
                g_in = 4'(15 - a);
                h_in = 1'(c);
                fo = ftt[a];
                go = gtt[15 - a];
                step();
                #2;
                chk("R6 X<-F", x_out, fo);
                chk("R6 Y<-H", y_out, htt[{h_in, go, fo}]);
            end
        end
        step();

        // R6/R7: X from G, Y from direct data; all pins data (enable defaults on)
        load_cfg(mk_cfg(ftt, gtt, htt, 8'h00, 2'd1, 2'd3, 0, 0, 1, 1, 0, 0), 1);
        for (int b = 0; b < 16; b++) begin
            g_in = 4'(b);
            ctl = 4'(b);
            step();
            #2;
            chk("R6 X<-G", x_out, gtt[b]);
            chk("R7 data OR, default enable", y_out, (b != 0));
        end
        ctl = 4'h0;
        step();

        // R7/R8: pin0 data, pin1 enable, pin2 set, pin3 reset
        load_cfg(mk_cfg(ftt, gtt, htt, 8'b11_10_01_00, 2'd3, 2'd3, 0, 0, 1, 1, 0, 0), 1);
        ctl = 4'b0011; step(); #2 chk("R7 enabled capture 1", x_out, 1'b1);
        ctl = 4'b0010; step(); #2 chk("R7 enabled capture 0", x_out, 1'b0);
        ctl = 4'b0001; step(); #2 chk("R7 disabled holds", x_out, 1'b0);
        step();
        ctl = 4'b0100; #0.5 chk("R8 set immediate", x_out, 1'b1);
        chk("R8 set immediate y", y_out, 1'b1);
        ctl = 4'b1100; #0.5 chk("R8 set beats reset", x_out, 1'b1);
        step();
        ctl = 4'b1000; #0.5 chk("R8 reset immediate", x_out, 1'b0);
        step();
        ctl = 4'b0000; #2 chk("R8 reset retained", x_out, 1'b0);
        step();
        ctl = 4'b0100; step();
        ctl = 4'b0000; #2 chk("R8 set retained", x_out, 1'b1);
        chk("R8 set retained y", y_out, 1'b1);

        // R11: a shift cycle clears the storage
        step();
        cfg_shift_en = 1'b1;
        cfg_din = 1'b0;
        step();
        cfg_shift_en = 1'b0;
        #2;
        chk("R11 hold clears x", x_out, 1'b0);
        chk("R11 hold clears y", y_out, 1'b0);
        step();

        // R9: latch mode, X from direct data, all pins data
        load_cfg(mk_cfg(ftt, gtt, htt, 8'h00, 2'd3, 2'd3, 0, 0, 1, 1, 1, 0), 1);
        ctl = 4'b0001; #0.5 chk("R9 transparent 1", x_out, 1'b1);
        ctl = 4'b0000; #0.2 chk("R9 transparent 0", x_out, 1'b0);
        ctl = 4'b0001; #1.3;
        chk("R9 held after fall", x_out, 1'b1);
        ctl = 4'b0000; #0.3 chk("R9 holds while low", x_out, 1'b1);
        chk("R9 holds while low y", y_out, 1'b1);
        step();
        #0.3 chk("R9 transparent again", x_out, 1'b0);
        step();

        // R10: carry mode, F table = f0 ^ f1 ^ index bit 3
        for (int i = 0; i < 16; i++) ftt[i] = ((i & 1) != 0) ^ ((i & 2) != 0) ^ ((i & 8) != 0);
        load_cfg(mk_cfg(ftt, gtt, htt, 8'h00, 2'd0, 2'd0, 0, 0, 0, 0, 0, 1), 1);
        for (int v = 0; v < 16; v++) begin
            logic a;
            logic b;
            logic ci;
            a = v[0];
            b = v[1];
            ci = v[2];
            f_in = {~ci, v[3], b, a};
            g_in = {3'b000, b};
            carry_in = ci;
            #0.5;
            chk("R10 sum", x_out, a ^ b ^ ci);
            chk("R10 carry out", carry_out, (a & b) | (ci & (a ^ b)));
        end
        step();

        // R10: carry disabled, carry passes and f_in[3] indexes F
        load_cfg(mk_cfg(ftt, gtt, htt, 8'h00, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0), 1);
        for (int a = 0; a < 16; a++) begin
            for (int c = 0; c < 2; c++) begin
                f_in = 4'(a);
                g_in = 4'hF;
                carry_in = 1'(c);
                #0.5;
                chk("R10 bypass F", x_out, ftt[a]);
                chk("R10 bypass carry", carry_out, 1'(c));
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule